// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block holds the rename map of an out-of-order core. For each architectural register it records one entry: a flag that says whether the value is still speculative, and the physical tag of the renamed value. When the flag is clear, the value lives in the architectural register file. In every cycle, two source registers are looked up combinationally from the live table. One destination mapping may be written at the following clock edge.

Every branch that renames takes a full snapshot of the live table into one slot of a small pool. The slot number goes back to the caller, which quotes it when the branch resolves. A correctly predicted branch hands back only its own slot. A mispredicted branch copies its snapshot into the live table in a single edge, and returns its slot together with every slot allocated after it.

A separate command clears every speculative flag and empties the pool. A core uses this to recover by draining: it waits until everything has committed, then points all registers back at the architectural file.

Top module: `ckpt_rat`

## Requirements
- R1: The source lookups show the live table combinationally. A destination write with `ren_dst_we` is visible from the next cycle as spec=1 with the written tag. At reset, every entry reads spec=0, tag=0.
- R2: `arch_reset` sets every entry to spec=0, tag=0 and frees every slot at the next edge. It takes priority over restore and rename in the same cycle.
- R3: A branch rename (`ren_valid` and `ren_is_branch`) that is accepted raises `br_grant` in the same cycle. `br_ckpt_id` gives the lowest-numbered free slot, and that slot becomes busy.
- R4: The snapshot holds the table as it was before the destination write of the same cycle.
- R5: `ckpt_stall` is high when all slots are busy. A branch rename in that state is refused as a whole: no grant and no destination write.
- R6: A mispredict resolve (`res_valid`, `res_mispredict`=1) on a busy slot loads that slot's snapshot into the live table, visible from the next cycle.
- R7: A mispredict frees the named slot and every slot allocated after it. Older slots stay busy.
- R8: A correct resolve (`res_mispredict`=0) frees only the named slot and leaves the live table unchanged.
- R9: When a restore and a rename fall in the same cycle, the rename is dropped: no write and no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_is_branch | input | 1 | Renamed instruction is a branch (takes a slot) |
| ren_src0 | input | 5 | First source architectural register |
| ren_src1 | input | 5 | Second source architectural register |
| ren_dst_we | input | 1 | Write a destination mapping |
| ren_dst | input | 5 | Destination architectural register |
| ren_dst_tag | input | 6 | New physical tag for the destination |
| src0_spec | output | 1 | First source is speculative (1) or architectural (0) |
| src0_tag | output | 6 | First source physical tag |
| src1_spec | output | 1 | Second source speculative flag |
| src1_tag | output | 6 | Second source physical tag |
| br_grant | output | 1 | Branch snapshot taken this cycle |
| br_ckpt_id | output | 2 | Slot assigned to the branch |
| ckpt_stall | output | 1 | No free slot |
| res_valid | input | 1 | Branch resolution |
| res_mispredict | input | 1 | 1 = restore, 0 = release |
| res_ckpt_id | input | 2 | Slot being resolved |
| arch_reset | input | 1 | Point every entry at the architectural file |

## Verification
Two pairs of functions can fall in the same cycle. A branch snapshot can coincide with a destination write. A mispredict restore can coincide with a branch rename that also writes a destination. The bench provokes the first pair by renaming a branch that writes r5. It then restores that slot and expects r5 to show its older tag again. It provokes the second pair by sending a mispredict together with a branch rename that writes r10, and expects no grant and r10 still architectural in the next cycle.

// File: rtl/ckpt_rat_pkg.sv
package ckpt_rat_pkg;
  // index of the lowest clear bit among the first n bits of v
  function automatic int lowest_clear(input logic [31:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) if (!v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] bit_of(input int idx);
    logic [31:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ckpt_pool.sv
module ckpt_pool #(
  parameter int NUM_CKPT = 4,
  localparam int ID_W = $clog2(NUM_CKPT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_all,
  input  logic                alloc_req,
  input  logic                release_req,
  input  logic                restore_req,
  input  logic [ID_W-1:0]     res_id,
  output logic [NUM_CKPT-1:0] busy_o,
  output logic                full_o,
  output logic [ID_W-1:0]     alloc_id_o
);
  import ckpt_rat_pkg::*;

  logic [NUM_CKPT-1:0] busy;
  logic [NUM_CKPT-1:0] younger [NUM_CKPT];
  logic [NUM_CKPT-1:0] kill_mask;
  logic [NUM_CKPT-1:0] claim_mask;

  assign busy_o     = busy;
  assign full_o     = &busy;
  assign alloc_id_o = ID_W'(lowest_clear(32'(busy), NUM_CKPT));
  assign claim_mask = alloc_req ? NUM_CKPT'(bit_of(int'(alloc_id_o))) : '0;

  always_comb begin
    kill_mask = '0;
    if (restore_req)
      kill_mask = (younger[res_id] & busy) | NUM_CKPT'(bit_of(int'(res_id)));
    else if (release_req)
      kill_mask = NUM_CKPT'(bit_of(int'(res_id)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < NUM_CKPT; i++) younger[i] <= '0;
    end else if (clear_all) begin
      busy <= '0;
    end else begin
      busy <= (busy & ~kill_mask) | claim_mask;
      if (alloc_req) begin
        for (int i = 0; i < NUM_CKPT; i++) younger[i][alloc_id_o] <= busy[i];
        younger[alloc_id_o] <= '0;
      end
    end
  end
endmodule

// File: rtl/ckpt_store.sv
module ckpt_store #(
  parameter int NUM_CKPT = 4,
  parameter int WIDTH    = 224,
  localparam int ID_W = $clog2(NUM_CKPT)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [ID_W-1:0]  rd_id,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot [NUM_CKPT];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_id] <= wr_data;
  end

  assign rd_data = slot[rd_id];
endmodule

// File: rtl/ckpt_rat.sv
module ckpt_rat #(
  parameter int NUM_ARCH = 32,
  parameter int TAG_W    = 6,
  parameter int NUM_CKPT = 4,
  localparam int AR_W  = $clog2(NUM_ARCH),
  localparam int ID_W  = $clog2(NUM_CKPT),
  localparam int ENT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  input  logic             ren_is_branch,
  input  logic [AR_W-1:0]  ren_src0,
  input  logic [AR_W-1:0]  ren_src1,
  input  logic             ren_dst_we,
  input  logic [AR_W-1:0]  ren_dst,
  input  logic [TAG_W-1:0] ren_dst_tag,
  output logic             src0_spec,
  output logic [TAG_W-1:0] src0_tag,
  output logic             src1_spec,
  output logic [TAG_W-1:0] src1_tag,
  output logic             br_grant,
  output logic [ID_W-1:0]  br_ckpt_id,
  output logic             ckpt_stall,
  input  logic             res_valid,
  input  logic             res_mispredict,
  input  logic [ID_W-1:0]  res_ckpt_id,
  input  logic             arch_reset
);
  // live table: entry = {spec, tag}
  logic [NUM_ARCH-1:0][ENT_W-1:0] live;
  logic [NUM_ARCH-1:0][ENT_W-1:0] saved;
  logic [NUM_CKPT-1:0] busy;
  logic [ID_W-1:0]     alloc_id;
  logic                pool_full;

  // named internal events
  logic do_restore, do_release, do_rename, do_alloc, do_write;

  assign do_restore = res_valid && res_mispredict && busy[res_ckpt_id] && !arch_reset;
  assign do_release = res_valid && !res_mispredict && busy[res_ckpt_id] && !arch_reset;
  assign do_rename  = ren_valid && !arch_reset && !do_restore && !(ren_is_branch && pool_full);
  assign do_alloc   = do_rename && ren_is_branch;
  assign do_write   = do_rename && ren_dst_we;

  assign br_grant   = do_alloc;
  assign br_ckpt_id = alloc_id;
  assign ckpt_stall = pool_full;

  assign {src0_spec, src0_tag} = live[ren_src0];
  assign {src1_spec, src1_tag} = live[ren_src1];

  ckpt_pool #(.NUM_CKPT(NUM_CKPT)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_all   (arch_reset),
    .alloc_req   (do_alloc),
    .release_req (do_release),
    .restore_req (do_restore),
    .res_id      (res_ckpt_id),
    .busy_o      (busy),
    .full_o      (pool_full),
    .alloc_id_o  (alloc_id)
  );

  ckpt_store #(.NUM_CKPT(NUM_CKPT), .WIDTH(NUM_ARCH*ENT_W)) u_store (
    .clk     (clk),
    .wr_en   (do_alloc),
    .wr_id   (alloc_id),
    .wr_data (live),
    .rd_id   (res_ckpt_id),
    .rd_data (saved)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          live <= '0;
    else if (arch_reset) live <= '0;
    else if (do_restore) live <= saved;
    else if (do_write)   live[ren_dst] <= {1'b1, ren_dst_tag};
  end
endmodule

// File: rtl/ckpt_rat_chk.sv
module ckpt_rat_chk #(
  parameter int NUM_CKPT = 4,
  localparam int ID_W = $clog2(NUM_CKPT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                arch_reset,
  input logic                ren_valid,
  input logic                ren_is_branch,
  input logic                ckpt_stall,
  input logic                br_grant,
  input logic [ID_W-1:0]     br_ckpt_id,
  input logic                do_restore,
  input logic                do_release,
  input logic [ID_W-1:0]     res_ckpt_id,
  input logic [NUM_CKPT-1:0] busy,
  input logic                src0_spec,
  input logic                src1_spec
);
  AST_STALL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && ren_is_branch && ckpt_stall |-> !br_grant); // R5
  AST_RESTORE_BEATS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |-> !br_grant); // R9
  AST_ARCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    arch_reset |=> !src0_spec && !src1_spec && busy == '0); // R2
  AST_GRANT_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    br_grant |=> busy[$past(br_ckpt_id)]); // R3
  AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> !busy[$past(res_ckpt_id)]); // R7
  AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    do_release && !br_grant |=> $countones(busy) == $past($countones(busy)) - 1); // R8
endmodule

bind ckpt_rat ckpt_rat_chk #(.NUM_CKPT(NUM_CKPT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .arch_reset    (arch_reset),
  .ren_valid     (ren_valid),
  .ren_is_branch (ren_is_branch),
  .ckpt_stall    (ckpt_stall),
  .br_grant      (br_grant),
  .br_ckpt_id    (br_ckpt_id),
  .do_restore    (do_restore),
  .do_release    (do_release),
  .res_ckpt_id   (res_ckpt_id),
  .busy          (busy),
  .src0_spec     (src0_spec),
  .src1_spec     (src1_spec)
);

// File: tb/ckpt_rat_test.sv
`timescale 1ns/1ps
module ckpt_rat_test;
  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, ren_is_branch = 0, ren_dst_we = 0;
  logic [4:0] ren_src0 = 0, ren_src1 = 0, ren_dst = 0;
  logic [5:0] ren_dst_tag = 0;
  logic src0_spec, src1_spec, br_grant, ckpt_stall;
  logic [5:0] src0_tag, src1_tag;
  logic [1:0] br_ckpt_id;
  logic res_valid = 0, res_mispredict = 0, arch_reset = 0;
  logic [1:0] res_ckpt_id = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic g_seen, s_seen;
  logic [1:0] id_seen;

  always #2.5 clk = ~clk;

  ckpt_rat uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, sample combinational outputs, then clear
  task automatic cyc(input bit rv, input bit br, input bit we, input int dst, input int tag,
                     input bit resv, input bit mis, input int rid, input bit ar);
    @(negedge clk);
    ren_valid = rv; ren_is_branch = br; ren_dst_we = we;
    ren_dst = 5'(dst); ren_dst_tag = 6'(tag);
    res_valid = resv; res_mispredict = mis; res_ckpt_id = 2'(rid); arch_reset = ar;
    #1;
    g_seen = br_grant; id_seen = br_ckpt_id; s_seen = ckpt_stall;
    @(posedge clk); #1;
    ren_valid = 0; ren_is_branch = 0; ren_dst_we = 0; res_valid = 0; arch_reset = 0;
  endtask

  // returns {spec, tag}
  task automatic look(input int r, output int ent);
    ren_src0 = 5'(r); ren_src1 = 5'(r); #0.5;
    ent = {src0_spec, src0_tag};
    check("R1 port1 agrees", {src1_spec, src1_tag}, ent);
  endtask

  function automatic int sp(input int tag); return 64 + tag; endfunction

  task automatic t_reset_state;
    int e;
    look(3, e); check("R1 reset entry", e, 0);
    check("R5 stall after reset", ckpt_stall, 0);
  endtask

  task automatic t_snapshot_and_restore;
    int e;
    cyc(1, 0, 1, 5, 10, 0, 0, 0, 0);
    look(5, e); check("R1 write visible", e, sp(10));
    cyc(1, 1, 1, 5, 20, 0, 0, 0, 0);
    check("R3 grant", g_seen, 1); check("R3 lowest id", id_seen, 0);
    look(5, e); check("R1 branch write visible", e, sp(20));
    cyc(1, 0, 1, 6, 33, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    look(5, e); check("R4 pre-write snapshot", e, sp(10));
    look(6, e); check("R6 restored entry", e, 0);
  endtask

  task automatic t_younger_freed;
    int e;
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R3 id A", id_seen, 0);
    cyc(1, 0, 1, 7, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 8, 2, 0, 0, 0, 0); check("R3 id B", id_seen, 1);
    cyc(1, 1, 1, 8, 3, 0, 0, 0, 0); check("R3 id C", id_seen, 2);
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0);
    look(8, e); check("R6 restore B", e, 0);
    look(7, e); check("R6 keeps older", e, sp(1));
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R7 reuse 1", id_seen, 1);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R7 reuse 2", id_seen, 2);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R7 then 3", id_seen, 3);
    #0.5 check("R5 stall when full", ckpt_stall, 1);
    cyc(1, 1, 1, 9, 4, 0, 0, 0, 0); check("R5 no grant", g_seen, 0);
    look(9, e); check("R5 write blocked", e, 0);
  endtask

  task automatic t_correct_release;
    int e;
    cyc(0, 0, 0, 0, 0, 1, 0, 2, 0);
    look(7, e); check("R8 table unchanged", e, sp(1));
    check("R8 stall drops", ckpt_stall, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R8 freed id", id_seen, 2);
    #0.5 check("R8 only one freed", ckpt_stall, 1);
  endtask

  task automatic t_restore_vs_rename;
    int e;
    cyc(1, 1, 1, 10, 5, 1, 1, 0, 0);
    check("R9 no grant", g_seen, 0);
    look(10, e); check("R9 write dropped", e, 0);
    look(7, e); check("R6 restore A", e, 0);
    check("R7 all younger freed", ckpt_stall, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R7 pool empty", id_seen, 0);
  endtask

  task automatic t_arch_reset;
    int e;
    cyc(1, 0, 1, 11, 7, 0, 0, 0, 0);
    cyc(1, 1, 1, 12, 8, 1, 1, 0, 1);
    check("R2 beats rename", g_seen, 0);
    look(11, e); check("R2 cleared", e, 0);
    look(12, e); check("R2 no write", e, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0); check("R2 pool empty", id_seen, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset_state();
    t_snapshot_and_restore();
    t_younger_freed();
    t_correct_release();
    t_restore_vs_rename();
    t_arch_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule